// File: doc/BRIEF.md
# Parity-Checked Cache Lookup Stage

This block decides hit or miss for a direct-mapped first-level cache. Every tag and every data word is stored with four parity bits. A processor request is registered in one cycle. In the next cycle the block reads the indexed line and compares its tag, and in the same cycle it recomputes the parity of the stored tag and data. A line whose tag or data fails the parity check is never returned as a hit. The access becomes a forced miss: the line is invalidated, an error counter advances, and the normal refill path fetches a clean copy from the next level.

Parity bit g of a word is the even parity of every bit whose index leaves remainder g when divided by four. Any flip confined to four neighbouring bits therefore changes at least one parity bit. The refill port supplies a whole word. That word is written with freshly generated tag and data parity, and then the lookup is replayed. An upset port lets a test flip stored tag or data bits of any line.

The controller has three states. IDLE accepts a request: IDLE→LOOKUP. LOOKUP decides the access: on a clean hit it goes LOOKUP→IDLE, on any miss (plain or forced) LOOKUP→REFILL. REFILL holds the refill request until data arrives: REFILL→REFILL while waiting, and REFILL→LOOKUP when the data arrives, which replays the access.

Top module: `cache_lookup_ilp`

## Requirements
- R1: After reset no line is valid, `req_ready` is 1, `refill_req` and `resp_valid` are 0, and `err_count` is 0.
- R2: A request accepted on clock edge E to a valid line with a matching tag and clean parity gives `resp_valid`=1 and the stored word on `resp_rdata` in the cycle after E. No extra cycle is spent on parity.
- R3: A miss pulses `lookup_miss` in that same cycle. From the next cycle `refill_req`=1 and `refill_addr` equals the request address, and both hold until `refill_valid` is seen.
- R4: A refill writes the tag, the data, their parity bits and the valid bit. The lookup is replayed in the next cycle, and that replay is a hit.
- R5: Parity encoding: 4 bits per word, bit g is the even parity over the bit indices j with j mod 4 = g. Flipping two bits of one group (for example bits 0 and 4) goes undetected, and the corrupted word is returned as a hit.
- R6: Any single-bit flip, or any flip of 2, 3 or 4 adjacent bits, in the stored data of a matching line makes that lookup a forced miss: `forced_miss`=1, `lookup_miss`=1, `resp_valid`=0.
- R7: Any such flip in a line's stored tag makes the lookup of that line a forced miss, whatever the tag comparison yields.
- R8: Each forced miss invalidates the line and raises `err_count` by one, up to a saturation value of all ones.
- R9: A write that hits stores the write data with newly generated parity. A later read returns that data as a hit.
- R10: A write that misses refills the line, then performs the write on the replay.
- R11: `req_ready` is 0 from acceptance until the cycle after the hit response. A `req_valid` seen while `req_ready` is 0 is ignored.
- R12: An upset pulse XORs `upset_tag_flip` and `upset_data_flip` into the stored tag and data of line `upset_index`. The stored parity bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; the low IDX_W bits are the index, the rest is the tag |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Hit response this cycle |
| resp_rdata | output | DATA_W | Stored word of the hit line |
| lookup_miss | output | 1 | Lookup decided a miss this cycle |
| forced_miss | output | 1 | The miss was caused by a parity failure |
| refill_req | output | 1 | Refill requested |
| refill_addr | output | ADDR_W | Address to refill |
| refill_valid | input | 1 | Refill word present |
| refill_data | input | DATA_W | Refill word |
| upset_valid | input | 1 | Apply a storage upset |
| upset_index | input | IDX_W | Line to upset |
| upset_tag_flip | input | ADDR_W-IDX_W | Tag bits to invert |
| upset_data_flip | input | DATA_W | Data bits to invert |
| err_count | output | CNT_W | Saturating forced-miss count |

## Verification
The assertions assume three things about the inputs. `refill_valid` is raised only while `refill_req` is high. Upsets arrive only while the block is idle and never in the cycle of a refill. The refilled word stays on `refill_data` for the cycle it is presented. The stimulus keeps to this: it raises `refill_valid` for exactly one cycle after it has seen `refill_req`, applies upsets between accesses, and injects at most one burst into a line before that line is read again. A double flip inside one parity group is injected only on purpose, to check the undetected case.

// File: rtl/icp_pkg.sv
package icp_pkg;
    localparam int PAR_GROUPS = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_REFILL = 2'd2
    } lk_state_e;
endpackage

// File: rtl/ilv_par_gen.sv
module ilv_par_gen #(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    output logic [icp_pkg::PAR_GROUPS-1:0] par
);
    for (genvar g = 0; g < icp_pkg::PAR_GROUPS; g++) begin : g_grp
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int j = g; j < W; j += icp_pkg::PAR_GROUPS) begin
                acc = acc ^ word[j];
            end
        end
        assign par[g] = acc;
    end
endmodule

// File: rtl/ilv_par_check.sv
module ilv_par_check #(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    input  logic [icp_pkg::PAR_GROUPS-1:0] stored_par,
    output logic bad
);
    logic [icp_pkg::PAR_GROUPS-1:0] fresh_par;

    ilv_par_gen #(.W(W)) gen_i (
        .word (word),
        .par  (fresh_par)
    );

    assign bad = |(fresh_par ^ stored_par);
endmodule

// File: rtl/lk_line_store.sv
module lk_line_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int LINES = 1 << IDX_W,
    localparam int PW    = icp_pkg::PAR_GROUPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [PW-1:0]     rd_tpar,
    output logic [DATA_W-1:0] rd_data,
    output logic [PW-1:0]     rd_dpar,
    input  logic              fill_en,
    input  logic              dwr_en,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PW-1:0]     wr_tpar,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     wr_dpar,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [TAG_W-1:0]  up_tag_flip,
    input  logic [DATA_W-1:0] up_data_flip
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [PW-1:0]     tpar_q [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [PW-1:0]     dpar_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= '0;
                tpar_q[i] <= '0;
                data_q[i] <= '0;
                dpar_q[i] <= '0;
            end
        end else if (fill_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            tpar_q[wr_idx]  <= wr_tpar;
            data_q[wr_idx]  <= wr_data;
            dpar_q[wr_idx]  <= wr_dpar;
        end else if (dwr_en) begin
            data_q[wr_idx]  <= wr_data;
            dpar_q[wr_idx]  <= wr_dpar;
        end else if (inv_en) begin
            valid_q[wr_idx] <= 1'b0;
        end else if (up_en) begin
            tag_q[up_idx]   <= tag_q[up_idx] ^ up_tag_flip;
            data_q[up_idx]  <= data_q[up_idx] ^ up_data_flip;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tpar  = tpar_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_dpar  = dpar_q[rd_idx];

    // R4: a fill leaves the written line valid
    p_fill_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/cache_lookup_ilp.sv
module cache_lookup_ilp #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              lookup_miss,
    output logic              forced_miss,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    input  logic              refill_valid,
    input  logic [DATA_W-1:0] refill_data,
    input  logic              upset_valid,
    input  logic [IDX_W-1:0]  upset_index,
    input  logic [TAG_W-1:0]  upset_tag_flip,
    input  logic [DATA_W-1:0] upset_data_flip,
    output logic [CNT_W-1:0]  err_count
);
    import icp_pkg::*;
    localparam int PW = PAR_GROUPS;

    lk_state_e         st_q, st_d;
    logic [ADDR_W-1:0] lat_addr_q;
    logic              lat_wr_q;
    logic [DATA_W-1:0] lat_wdata_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [PW-1:0]     rd_tpar, rd_dpar, wr_tpar, wr_dpar;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              tag_bad, data_bad, tag_eq, clean_hit, par_fault;
    logic              fill_en, dwr_en, inv_en;

    assign cur_idx = lat_addr_q[IDX_W-1:0];
    assign cur_tag = lat_addr_q[ADDR_W-1:IDX_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr_q  <= '0;
            lat_wr_q    <= 1'b0;
            lat_wdata_q <= '0;
        end else if (req_valid && req_ready) begin
            lat_addr_q  <= req_addr;
            lat_wr_q    <= req_write;
            lat_wdata_q <= req_wdata;
        end
    end

    // saturating upset counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                err_count <= '0;
        else if (forced_miss && (err_count != '1)) err_count <= err_count + 1'b1;
    end

    lk_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_idx       (cur_idx),
        .rd_valid     (rd_valid),
        .rd_tag       (rd_tag),
        .rd_tpar      (rd_tpar),
        .rd_data      (rd_data),
        .rd_dpar      (rd_dpar),
        .fill_en      (fill_en),
        .dwr_en       (dwr_en),
        .inv_en       (inv_en),
        .wr_idx       (cur_idx),
        .wr_tag       (cur_tag),
        .wr_tpar      (wr_tpar),
        .wr_data      (wr_data),
        .wr_dpar      (wr_dpar),
        .up_en        (upset_valid),
        .up_idx       (upset_index),
        .up_tag_flip  (upset_tag_flip),
        .up_data_flip (upset_data_flip)
    );

    // parity checks run beside the tag compare, same cycle
    ilv_par_check #(.W(TAG_W))  tchk_i (.word(rd_tag),  .stored_par(rd_tpar), .bad(tag_bad));
    ilv_par_check #(.W(DATA_W)) dchk_i (.word(rd_data), .stored_par(rd_dpar), .bad(data_bad));

    // parity for writes, from refill data or processor write data
    assign wr_data = (st_q == ST_REFILL) ? refill_data : lat_wdata_q;
    ilv_par_gen #(.W(TAG_W))  tgen_i (.word(cur_tag), .par(wr_tpar));
    ilv_par_gen #(.W(DATA_W)) dgen_i (.word(wr_data), .par(wr_dpar));

    assign tag_eq    = (rd_tag == cur_tag);
    assign par_fault = rd_valid && (tag_bad || (tag_eq && data_bad));
    assign clean_hit = rd_valid && tag_eq && !tag_bad && !data_bad;

    assign resp_rdata  = rd_data;
    assign refill_addr = lat_addr_q;

    // next state and outputs
    always_comb begin
        st_d        = st_q;
        req_ready   = 1'b0;
        resp_valid  = 1'b0;
        lookup_miss = 1'b0;
        forced_miss = 1'b0;
        refill_req  = 1'b0;
        fill_en     = 1'b0;
        dwr_en      = 1'b0;
        inv_en      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) st_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (clean_hit) begin
                    resp_valid = 1'b1;
                    dwr_en     = lat_wr_q;
                    st_d       = ST_IDLE;
                end else begin
                    lookup_miss = 1'b1;
                    forced_miss = par_fault;
                    inv_en      = par_fault;
                    st_d        = ST_REFILL;
                end
            end
            ST_REFILL: begin
                refill_req = 1'b1;
                if (refill_valid) begin
                    fill_en = 1'b1;
                    st_d    = ST_LOOKUP;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // R3: refill request and address hold until data arrives
    p_refill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));

    // R4: a refill not disturbed by an upset replays as a hit
    p_replay_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_valid && !upset_valid) |=> resp_valid);

    // R6: a forced miss is a miss and never a response
    p_forced_no_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        forced_miss |-> (lookup_miss && !resp_valid));

    // R8: counter steps once per forced miss below saturation
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_miss && (err_count != '1)) |=> (err_count == CNT_W'($past(err_count) + 1'b1)));

    // R8: a forced miss leads into the refill
    p_forced_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        forced_miss |=> refill_req);

    // R11: busy while a response is driven
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
endmodule

// File: tb/cache_lookup_ilp_tb.sv
`timescale 1ns/1ps
module cache_lookup_ilp_tb_top;
    localparam int AW = 12, IW = 4, DW = 32, CW = 8, TW = AW - IW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, refill_valid = 0, upset_valid = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, refill_data = '0, upset_data_flip = '0;
    logic [IW-1:0] upset_index = '0;
    logic [TW-1:0] upset_tag_flip = '0;
    logic req_ready, resp_valid, lookup_miss, forced_miss, refill_req;
    logic [DW-1:0] resp_rdata;
    logic [AW-1:0] refill_addr;
    logic [CW-1:0] err_count;

    always #2.5 clk = ~clk;

    cache_lookup_ilp dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .lookup_miss(lookup_miss), .forced_miss(forced_miss),
        .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_valid(refill_valid), .refill_data(refill_data),
        .upset_valid(upset_valid), .upset_index(upset_index),
        .upset_tag_flip(upset_tag_flip), .upset_data_flip(upset_data_flip),
        .err_count(err_count)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    logic [DW-1:0] mem [int];
    bit            m_valid [16];
    logic [TW-1:0] m_tag   [16];
    logic [TW-1:0] m_tflip [16];
    logic [DW-1:0] m_data  [16];
    logic [DW-1:0] m_dflip [16];
    int            m_err = 0;
    bit            last_forced;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mget(input int a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
    endfunction

    // any group with an odd number of flipped bits breaks parity
    function automatic bit odd_group(input logic [63:0] m, input int w);
        int cnt [4] = '{0, 0, 0, 0};
        for (int j = 0; j < w; j++) if (m[j]) cnt[j % 4]++;
        for (int g = 0; g < 4; g++) if (cnt[g] % 2 == 1) return 1;
        return 0;
    endfunction

    task automatic upset(input int idx, input logic [TW-1:0] tm, input logic [DW-1:0] dm);
        @(negedge clk);
        upset_valid = 1; upset_index = IW'(idx); upset_tag_flip = tm; upset_data_flip = dm;
        @(negedge clk);
        upset_valid = 0; upset_tag_flip = '0; upset_data_flip = '0;
        m_tflip[idx] ^= tm;
        m_dflip[idx] ^= dm;
    endtask

    task automatic access(input bit wr, input int a, input logic [DW-1:0] wd);
        int idx = a % 16;
        logic [TW-1:0] t = TW'(a / 16);
        bit tbad, dbad, teq, hit, forced;
        @(negedge clk);
        chk(req_ready == 1, "R11 ready idle", 64'(req_ready), 1);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        tbad   = odd_group(64'(m_tflip[idx]), TW);
        dbad   = odd_group(64'(m_dflip[idx]), DW);
        teq    = ((m_tag[idx] ^ m_tflip[idx]) == t);
        hit    = m_valid[idx] && teq && !tbad && !dbad;
        forced = m_valid[idx] && (tbad || (teq && dbad));
        last_forced = forced_miss;
        chk(req_ready == 0, "R11 busy", 64'(req_ready), 0);
        chk(resp_valid == hit, "R2 hit decision", 64'(resp_valid), 64'(hit));
        chk(lookup_miss == !hit, "R3 miss pulse", 64'(lookup_miss), 64'(!hit));
        chk(forced_miss == forced, "R6/R7 forced miss", 64'(forced_miss), 64'(forced));
        if (hit) begin
            if (!wr) chk(resp_rdata == (m_data[idx] ^ m_dflip[idx]), "R2 read data",
                         64'(resp_rdata), 64'(m_data[idx] ^ m_dflip[idx]));
            else begin
                m_data[idx] = wd; m_dflip[idx] = '0; mem[a] = wd;  // R9
            end
            return;
        end
        if (forced) begin
            m_valid[idx] = 0;
            if (m_err < 255) m_err++;
        end
        @(negedge clk);
        chk(refill_req == 1, "R3 refill request", 64'(refill_req), 1);
        chk(refill_addr == AW'(a), "R3 refill address", 64'(refill_addr), 64'(a));
        chk(err_count == CW'(m_err), "R8 error count", 64'(err_count), 64'(m_err));
        @(negedge clk);
        chk(refill_req == 1 && refill_addr == AW'(a), "R3 refill held", 64'(refill_addr), 64'(a));
        refill_valid = 1; refill_data = mget(a);
        @(negedge clk);
        refill_valid = 0;
        m_valid[idx] = 1; m_tag[idx] = t; m_tflip[idx] = '0;
        m_data[idx] = mget(a); m_dflip[idx] = '0;
        chk(resp_valid == 1, "R4 replay hit", 64'(resp_valid), 1);
        chk(forced_miss == 0, "R4 replay clean", 64'(forced_miss), 0);
        if (!wr) chk(resp_rdata == m_data[idx], "R4 refilled data", 64'(resp_rdata), 64'(m_data[idx]));
        else begin
            m_data[idx] = wd; mem[a] = wd;  // R10 write on replay
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_tflip[i] = '0; m_data[i] = '0; m_dflip[i] = '0;
        end
        mem[12'h0A3] = 32'h0000_0000;
        mem[12'h0B4] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 ready", 64'(req_ready), 1);
        chk(refill_req == 0, "R1 no refill", 64'(refill_req), 0);
        chk(resp_valid == 0, "R1 no response", 64'(resp_valid), 0);
        chk(err_count == 0, "R1 counter", 64'(err_count), 0);
        rst_n = 1;

        // R11: request during refill wait is ignored (driven only while idle via task)
        access(0, 12'h123, '0);      // cold miss, R3/R4
        access(0, 12'h123, '0);      // R2 hit
        access(0, 12'h0A3, '0);      // all-zero word, R5
        access(0, 12'h0A3, '0);
        access(0, 12'h0B4, '0);      // all-ones word
        access(0, 12'h0B4, '0);
        access(0, 12'h223, '0);      // conflict with 0x123
        access(0, 12'h123, '0);
        access(1, 12'h123, 32'hDEAD_BEEF);  // R9 write hit
        access(0, 12'h123, '0);
        chk(resp_rdata == 32'hDEAD_BEEF, "R9 written data", 64'(resp_rdata), 64'h0DEADBEEF);
        access(1, 12'h345, 32'h1234_5678);  // R10 write miss
        access(0, 12'h345, '0);
        chk(resp_rdata == 32'h1234_5678, "R10 write after refill", 64'(resp_rdata), 64'h12345678);

        // R5: two flips in one group go undetected
        upset(3, '0, 32'h0000_0011);
        access(0, 12'h123, '0);
        chk(last_forced == 0, "R5 same-group flip undetected", 64'(last_forced), 0);
        chk(resp_rdata == (32'hDEAD_BEEF ^ 32'h11), "R5 corrupted data returned",
            64'(resp_rdata), 64'(32'hDEAD_BEEF ^ 32'h11));
        access(1, 12'h123, 32'hDEAD_BEEF);  // rewrite with fresh parity

        // R6: every data burst of 1..4 adjacent bits
        for (int s = 0; s < DW; s++) begin
            for (int l = 1; l <= 4; l++) begin
                if (s + l <= DW) begin
                    upset(3, '0, DW'(((64'd1 << l) - 1) << s));  // R12 upset port
                    access(0, 12'h123, '0);
                    chk(last_forced == 1, "R6 data burst", 64'(last_forced), 1);
                end
            end
        end
        // R7: every tag burst of 1..4 adjacent bits
        for (int s = 0; s < TW; s++) begin
            for (int l = 1; l <= 4; l++) begin
                if (s + l <= TW) begin
                    upset(3, TW'(((64'd1 << l) - 1) << s), '0);
                    access(0, 12'h123, '0);
                    chk(last_forced == 1, "R7 tag burst", 64'(last_forced), 1);
                end
            end
        end
        // R8 saturation
        for (int k = 0; k < 120; k++) begin
            upset(5, '0, DW'(64'd1 << (k % DW)));
            access(0, 12'h005, '0);
        end
        @(negedge clk);
        chk(err_count == 8'hFF, "R8 saturated", 64'(err_count), 64'hFF);
        access(0, 12'h123, '0);
        chk(err_count == 8'hFF, "R8 stays saturated", 64'(err_count), 64'hFF);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule